// File: doc/BRIEF.md
# Blade-Indexed Multiply-Accumulate Core with Hazard Stall

This block is the arithmetic heart of a geometric-product engine. Each accepted input pairs two signed coefficients with the bitmaps of their basis blades. The core works out the result blade as the XOR of the two bitmaps. It derives the sign from two sources: the parity of the basis-vector swaps needed to reorder the product, and a per-vector signature mask. It multiplies the coefficients in a five-stage pipeline and applies the sign. A six-stage adder then sums the result with the value an external register file holds for that blade, and writes the sum back to the file.

Blade and valid shift registers run beside both arithmetic pipelines. A read-after-write hazard exists when the blade at the multiplier output is still being summed somewhere in the adder. The core then freezes its front end and sends invalid blade-0 bubbles into the adder until the earlier sum has been written. The stall is also given to the operand fetcher, which must hold its operands while the stall is high.

Top module: `ga_blade_mac`

## Requirements
- R1: The blade written to the register file is `bladeA XOR bladeB` of the accepted operand pair.
- R2: The product is negated when the swap count is odd. The swap count is the number of pairs (i, j) where bit i is set in bladeA, bit j is set in bladeB, and i > j.
- R3: The product is also negated once for every bit set in all three of bladeA, bladeB and sigMask.
- R4: With no stall, an operand accepted at a rising clock edge gives a write strobe `rfWrEn` that is visible 11 cycles after that edge.
- R5: The written data is the low 32 bits of the signed coefficient product, with the sign applied, plus `rfRdData`. `rfRdData` is read at `rfRdSel`, the multiplier-output blade. A register-file miss must return zero.
- R6: `stallOut` is high exactly when the multiplier output is valid and some valid adder stage holds the same blade.
- R7: While `stallOut` is high, the operand inputs are not taken and the multiplier output (`rfRdSel`) is held. The adder still advances and receives invalid bubbles.
- R8: The stall drops in the cycle after the conflicting sum is written. Two same-blade operands accepted back to back have their writes 7 cycles apart. They stall for 6 cycles, and the second sum includes the first.
- R9: After reset, `rfWrEn` and `stallOut` are low and `pipeIdle` is high.
- R10: `pipeIdle` is high exactly when no pipeline stage holds valid data.
- R11: Operands presented with `inValid` low produce no register-file write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operand pair is valid |
| coefA | input | 32 | First signed coefficient |
| coefB | input | 32 | Second signed coefficient |
| bladeA | input | 8 | Basis bitmap of the first operand |
| bladeB | input | 8 | Basis bitmap of the second operand |
| sigMask | input | 8 | Basis vectors that square to -1 |
| stallOut | output | 1 | Hazard stall; the fetcher must hold its operands |
| rfRdSel | output | 8 | Register-file read blade |
| rfRdData | input | 32 | Register-file read value (zero on miss) |
| rfWrSel | output | 8 | Register-file write blade |
| rfWrData | output | 32 | Register-file write value |
| rfWrEn | output | 1 | Register-file write strobe |
| pipeIdle | output | 1 | No valid data in any stage |

## Verification
The assertions check on every cycle that the read blade stays frozen through a stall, and that the stall clears once the matching sum has been written. They also check that an idle pipeline neither stalls nor writes on the next cycle, and that a write only happens while the pipeline is busy. Only the bench scenarios can show the arithmetic: swap-parity and signature signs, accumulation across repeated blades, the 11-cycle latency, the 7-cycle write gap and the 6-cycle stall for back-to-back hazards. Against a bench model of the register file, they also show that no operands are lost or duplicated while stalled.

// File: rtl/ga_mac_pkg.sv
package ga_mac_pkg;
  parameter int DATA_W = 32;
  parameter int BLADE_W = 8;
  parameter int MUL_STAGES = 5;
  parameter int ADD_STAGES = 6;

  typedef struct packed {
    logic frontAdv;   // advance input register and multiplier pipeline
    logic adderLoad;  // load a valid product into the adder head
  } ctrlStrobes_t;
endpackage

// File: rtl/ga_blade_sign.sv
module ga_blade_sign #(
  parameter int BLADE_W = 8
) (
  input  logic [BLADE_W-1:0] bladeA,
  input  logic [BLADE_W-1:0] bladeB,
  input  logic [BLADE_W-1:0] sigMask,
  output logic [BLADE_W-1:0] bladeOut,
  output logic               negOut
);
  logic swapPar;
  logic metricPar;

  assign bladeOut = bladeA ^ bladeB;

  // Reordering parity: each set bit of B passes every higher set bit of A
  always_comb begin
    swapPar = 1'b0;
    for (int j = 0; j < BLADE_W; j++) begin
      if (bladeB[j]) begin
        for (int i = j + 1; i < BLADE_W; i++) begin
          swapPar = swapPar ^ bladeA[i];
        end
      end
    end
  end

  // Shared vectors with negative square each contribute one sign flip
  assign metricPar = ^(bladeA & bladeB & sigMask);
  assign negOut = swapPar ^ metricPar;
endmodule

// File: rtl/ga_mac_control.sv
module ga_mac_control
  import ga_mac_pkg::*;
#(
  parameter int BLADE_W = 8,
  parameter int ADD_STAGES = 6
) (
  input  logic                                 frontBusy,
  input  logic                                 mulTailValid,
  input  logic [BLADE_W-1:0]                   mulTailBlade,
  input  logic [ADD_STAGES-1:0]                addValid,
  input  logic [ADD_STAGES-1:0][BLADE_W-1:0]   addBlade,
  output ctrlStrobes_t                         ctrl,
  output logic                                 stall,
  output logic                                 pipeIdle
);
  logic [ADD_STAGES-1:0] stageHit;

  for (genvar k = 0; k < ADD_STAGES; k++) begin : g_match
    assign stageHit[k] = addValid[k] && (addBlade[k] == mulTailBlade);
  end

  assign stall = mulTailValid && (|stageHit);
  assign ctrl.frontAdv = !stall;
  assign ctrl.adderLoad = mulTailValid && !stall;
  assign pipeIdle = !frontBusy && !(|addValid);
endmodule

// File: rtl/ga_mac_datapath.sv
module ga_mac_datapath
  import ga_mac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BLADE_W = 8,
  parameter int MUL_STAGES = 5,
  parameter int ADD_STAGES = 6
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  ctrlStrobes_t                        ctrl,
  input  logic                                inValid,
  input  logic [DATA_W-1:0]                   coefA,
  input  logic [DATA_W-1:0]                   coefB,
  input  logic [BLADE_W-1:0]                  inBlade,
  input  logic                                inNeg,
  input  logic [DATA_W-1:0]                   rfRdData,
  output logic                                frontBusy,
  output logic                                mulTailValid,
  output logic [BLADE_W-1:0]                  mulTailBlade,
  output logic [ADD_STAGES-1:0]               addValid,
  output logic [ADD_STAGES-1:0][BLADE_W-1:0]  addBlade,
  output logic [DATA_W-1:0]                   wrData
);
  localparam int PROD_W = 2 * DATA_W;
  localparam int MT = MUL_STAGES - 1;
  localparam int AT = ADD_STAGES - 1;

  logic                                s0Valid;
  logic                                s0Neg;
  logic [BLADE_W-1:0]                  s0Blade;
  logic [DATA_W-1:0]                   s0A;
  logic [DATA_W-1:0]                   s0B;
  logic [MUL_STAGES-1:0]               mulValid;
  logic [MUL_STAGES-1:0][BLADE_W-1:0]  mulBlade;
  logic [MUL_STAGES-1:0][DATA_W-1:0]   mulProd;
  logic [ADD_STAGES-1:0][DATA_W-1:0]   addSum;
  logic signed [PROD_W-1:0]            fullProd;
  logic [DATA_W-1:0]                   rawProd;
  logic [DATA_W-1:0]                   signedProd;

  assign fullProd = $signed(s0A) * $signed(s0B);
  assign rawProd = fullProd[DATA_W-1:0];
  assign signedProd = s0Neg ? (~rawProd + 1'b1) : rawProd;

  // Front end: input register plus multiplier pipeline, frozen by stall
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s0Valid <= 1'b0;
      s0Neg <= 1'b0;
      s0Blade <= '0;
      s0A <= '0;
      s0B <= '0;
      mulValid <= '0;
      mulBlade <= '0;
      mulProd <= '0;
    end else if (ctrl.frontAdv) begin
      s0Valid <= inValid;
      s0Neg <= inNeg;
      s0Blade <= inBlade;
      s0A <= coefA;
      s0B <= coefB;
      mulValid[0] <= s0Valid;
      mulBlade[0] <= s0Blade;
      mulProd[0] <= signedProd;
      for (int k = 1; k < MUL_STAGES; k++) begin
        mulValid[k] <= mulValid[k-1];
        mulBlade[k] <= mulBlade[k-1];
        mulProd[k] <= mulProd[k-1];
      end
    end
  end

  // Adder pipeline never freezes; bubbles enter as blade 0, invalid
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addValid <= '0;
      addBlade <= '0;
      addSum <= '0;
    end else begin
      addValid[0] <= ctrl.adderLoad;
      addBlade[0] <= ctrl.adderLoad ? mulBlade[MT] : '0;
      addSum[0] <= ctrl.adderLoad ? (mulProd[MT] + rfRdData) : '0;
      for (int k = 1; k < ADD_STAGES; k++) begin
        addValid[k] <= addValid[k-1];
        addBlade[k] <= addBlade[k-1];
        addSum[k] <= addSum[k-1];
      end
    end
  end

  assign frontBusy = s0Valid || (|mulValid);
  assign mulTailValid = mulValid[MT];
  assign mulTailBlade = mulBlade[MT];
  assign wrData = addSum[AT];
endmodule

// File: rtl/ga_blade_mac.sv
module ga_blade_mac
  import ga_mac_pkg::*;
#(
  parameter int DATA_W = ga_mac_pkg::DATA_W,
  parameter int BLADE_W = ga_mac_pkg::BLADE_W,
  parameter int MUL_STAGES = ga_mac_pkg::MUL_STAGES,
  parameter int ADD_STAGES = ga_mac_pkg::ADD_STAGES
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [DATA_W-1:0]  coefA,
  input  logic [DATA_W-1:0]  coefB,
  input  logic [BLADE_W-1:0] bladeA,
  input  logic [BLADE_W-1:0] bladeB,
  input  logic [BLADE_W-1:0] sigMask,
  output logic               stallOut,
  output logic [BLADE_W-1:0] rfRdSel,
  input  logic [DATA_W-1:0]  rfRdData,
  output logic [BLADE_W-1:0] rfWrSel,
  output logic [DATA_W-1:0]  rfWrData,
  output logic               rfWrEn,
  output logic               pipeIdle
);
  localparam int AT = ADD_STAGES - 1;

  ctrlStrobes_t                       ctrl;
  logic [BLADE_W-1:0]                 inBlade;
  logic                               inNeg;
  logic                               frontBusy;
  logic                               mulTailValid;
  logic [BLADE_W-1:0]                 mulTailBlade;
  logic [ADD_STAGES-1:0]              addValid;
  logic [ADD_STAGES-1:0][BLADE_W-1:0] addBlade;

  ga_blade_sign #(.BLADE_W(BLADE_W)) u_sign (
    .bladeA(bladeA), .bladeB(bladeB), .sigMask(sigMask),
    .bladeOut(inBlade), .negOut(inNeg)
  );

  ga_mac_control #(.BLADE_W(BLADE_W), .ADD_STAGES(ADD_STAGES)) u_ctrl (
    .frontBusy(frontBusy), .mulTailValid(mulTailValid), .mulTailBlade(mulTailBlade),
    .addValid(addValid), .addBlade(addBlade),
    .ctrl(ctrl), .stall(stallOut), .pipeIdle(pipeIdle)
  );

  ga_mac_datapath #(
    .DATA_W(DATA_W), .BLADE_W(BLADE_W), .MUL_STAGES(MUL_STAGES), .ADD_STAGES(ADD_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .inValid(inValid),
    .coefA(coefA), .coefB(coefB), .inBlade(inBlade), .inNeg(inNeg),
    .rfRdData(rfRdData), .frontBusy(frontBusy),
    .mulTailValid(mulTailValid), .mulTailBlade(mulTailBlade),
    .addValid(addValid), .addBlade(addBlade), .wrData(rfWrData)
  );

  assign rfRdSel = mulTailBlade;
  assign rfWrSel = addBlade[AT];
  assign rfWrEn = addValid[AT];
endmodule

// File: rtl/ga_blade_mac_chk.sv
module ga_blade_mac_chk #(
  parameter int BLADE_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               stallOut,
  input logic               rfWrEn,
  input logic               pipeIdle,
  input logic [BLADE_W-1:0] rfRdSel,
  input logic [BLADE_W-1:0] rfWrSel
);
  AST_STALL_FREEZES_READ: assert property (@(posedge clk) disable iff (!rstN)
    stallOut |=> $stable(rfRdSel)); // R7

  AST_STALL_CLEARS_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (stallOut && rfWrEn && (rfWrSel == rfRdSel)) |=> !stallOut); // R8

  AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rstN)
    pipeIdle |-> !stallOut); // R6

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    pipeIdle |=> !rfWrEn); // R11

  AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> !pipeIdle); // R10
endmodule

bind ga_blade_mac ga_blade_mac_chk #(.BLADE_W(BLADE_W)) u_chk (
  .clk(clk), .rstN(rstN), .stallOut(stallOut), .rfWrEn(rfWrEn),
  .pipeIdle(pipeIdle), .rfRdSel(rfRdSel), .rfWrSel(rfWrSel)
);

// File: tb/ga_blade_mac_tb.sv
module ga_blade_mac_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] coefA = '0;
  logic [31:0] coefB = '0;
  logic [7:0]  bladeA = '0;
  logic [7:0]  bladeB = '0;
  logic [7:0]  sigMask = '0;
  logic        stallOut;
  logic [7:0]  rfRdSel;
  logic [31:0] rfRdData;
  logic [7:0]  rfWrSel;
  logic [31:0] rfWrData;
  logic        rfWrEn;
  logic        pipeIdle;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  logic [31:0] rfMem [256];
  logic [31:0] accModel [256];
  logic [7:0]  expBladeQ [$];
  logic [31:0] expProdQ [$];
  int          wrCount = 0;
  int          wrCycle [64];
  logic [7:0]  lastWrSel;
  logic [31:0] lastWrData;
  int          stallCount = 0;
  int          lastAcc = 0;

  ga_blade_mac u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .coefA(coefA), .coefB(coefB),
    .bladeA(bladeA), .bladeB(bladeB), .sigMask(sigMask), .stallOut(stallOut),
    .rfRdSel(rfRdSel), .rfRdData(rfRdData), .rfWrSel(rfWrSel),
    .rfWrData(rfWrData), .rfWrEn(rfWrEn), .pipeIdle(pipeIdle)
  );

  always #2 clk = ~clk;

  assign rfRdData = rfMem[rfRdSel];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rstN && rfWrEn) rfMem[rfWrSel] <= rfWrData;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: every write must match the next accepted operand in order
  always @(negedge clk) begin
    if (rstN && stallOut) stallCount++;
    if (rstN && rfWrEn) begin
      if (wrCount < 64) wrCycle[wrCount] = cyc;
      wrCount++;
      lastWrSel = rfWrSel;
      lastWrData = rfWrData;
      if (expBladeQ.size() == 0) begin
        check(0, "R11 unexpected write", rfWrSel, -1);
      end else begin
        logic [7:0] eb;
        logic [31:0] ed;
        eb = expBladeQ.pop_front();
        ed = accModel[eb] + expProdQ.pop_front();
        accModel[eb] = ed;
        check(rfWrSel == eb, "R1 write blade", rfWrSel, eb);
        check(rfWrData == ed, "R5 write data", $signed(rfWrData), $signed(ed));
      end
    end
  end

  function automatic bit modelNeg(input logic [7:0] a, input logic [7:0] b, input logic [7:0] m);
    bit n = 0;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < i; j++)
        if (a[i] && b[j]) n = ~n;
    for (int k = 0; k < 8; k++)
      if (a[k] && b[k] && m[k]) n = ~n;
    return n;
  endfunction

  task automatic doReset();
    inValid = 1'b0;
    rstN = 1'b0;
    for (int i = 0; i < 256; i++) begin
      rfMem[i] = '0;
      accModel[i] = '0;
    end
    expBladeQ.delete();
    expProdQ.delete();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    wrCount = 0;
    stallCount = 0;
  endtask

  task automatic sendOp(input logic [7:0] a, input logic [7:0] b, input logic [7:0] m,
                        input logic [31:0] ca, input logic [31:0] cb);
    logic [31:0] p;
    @(negedge clk);
    inValid = 1'b1;
    bladeA = a;
    bladeB = b;
    sigMask = m;
    coefA = ca;
    coefB = cb;
    while (stallOut) @(negedge clk);
    p = ca * cb;
    if (modelNeg(a, b, m)) p = -p;
    expBladeQ.push_back(a ^ b);
    expProdQ.push_back(p);
    lastAcc = cyc + 1;
    @(posedge clk);
  endtask

  task automatic idleIn();
    @(negedge clk);
    inValid = 1'b0;
    coefA = 32'hDEAD_BEEF;
    coefB = 32'h1234_5678;
  endtask

  task automatic drain();
    repeat (40) @(negedge clk);
  endtask

  task automatic testReset();
    doReset();
    check(rfWrEn == 1'b0, "R9 write strobe low", rfWrEn, 0);
    check(stallOut == 1'b0, "R9 stall low", stallOut, 0);
    check(pipeIdle == 1'b1, "R9 idle high", pipeIdle, 1);
  endtask

  task automatic testSingle();
    int acc;
    doReset();
    sendOp(8'h02, 8'h01, 8'h00, 32'd3, 32'd5);
    acc = lastAcc;
    idleIn();
    check(pipeIdle == 1'b0, "R10 busy after accept", pipeIdle, 0);
    drain();
    check(wrCount == 1, "R11 one write", wrCount, 1);
    check(lastWrSel == 8'h03, "R1 blade e2*e1", lastWrSel, 3);
    check($signed(lastWrData) == -15, "R2 swap sign", $signed(lastWrData), -15);
    check(wrCycle[0] - acc == 11, "R4 latency", wrCycle[0] - acc, 11);
    check(pipeIdle == 1'b1, "R10 idle after drain", pipeIdle, 1);
  endtask

  task automatic testSignature();
    doReset();
    sendOp(8'h01, 8'h01, 8'h01, 32'd7, 32'd4);
    idleIn();
    drain();
    check($signed(lastWrData) == -28, "R3 negative square", $signed(lastWrData), -28);
    check(lastWrSel == 8'h00, "R1 self product scalar", lastWrSel, 0);
    doReset();
    sendOp(8'h03, 8'h03, 8'h02, 32'd6, 32'd2);
    idleIn();
    drain();
    check($signed(lastWrData) == 12, "R3 swap and metric cancel", $signed(lastWrData), 12);
  endtask

  task automatic testHazard();
    doReset();
    sendOp(8'h04, 8'h00, 8'h00, 32'd2, 32'd3);
    sendOp(8'h00, 8'h04, 8'h00, 32'd10, 32'd10);
    idleIn();
    drain();
    check(wrCount == 2, "R7 held operand taken once", wrCount, 2);
    check(wrCycle[1] - wrCycle[0] == 7, "R8 write gap", wrCycle[1] - wrCycle[0], 7);
    check(stallCount == 6, "R6 stall cycles", stallCount, 6);
    check(lastWrData == 32'd106, "R8 second sum includes first", lastWrData, 106);
  endtask

  task automatic testNoHazard();
    doReset();
    sendOp(8'h01, 8'h00, 8'h00, 32'd1, 32'd1);
    sendOp(8'h02, 8'h00, 8'h00, 32'd2, 32'd1);
    sendOp(8'h04, 8'h00, 8'h00, 32'd3, 32'd1);
    idleIn();
    drain();
    check(stallCount == 0, "R6 no stall for distinct blades", stallCount, 0);
    check(wrCycle[1] - wrCycle[0] == 1, "R4 back-to-back gap", wrCycle[1] - wrCycle[0], 1);
    check(wrCycle[2] - wrCycle[1] == 1, "R4 back-to-back gap", wrCycle[2] - wrCycle[1], 1);
  endtask

  task automatic testInvalid();
    doReset();
    @(negedge clk);
    inValid = 1'b0;
    bladeA = 8'h05;
    bladeB = 8'h03;
    coefA = 32'd99;
    coefB = 32'd77;
    repeat (25) @(negedge clk);
    check(wrCount == 0, "R11 invalid operands not written", wrCount, 0);
    check(pipeIdle == 1'b1, "R10 idle with invalid input", pipeIdle, 1);
  endtask

  task automatic testStream();
    doReset();
    for (int n = 0; n < 24; n++) begin
      sendOp(8'(n % 3), 8'(((n * 5) % 4) << 1), 8'(n % 4), 32'(n * 37 - 300), 32'(17 - n));
      if (n % 5 == 4) idleIn();
    end
    idleIn();
    drain();
    check(wrCount == 24, "R5 all stream results written", wrCount, 24);
    check(expBladeQ.size() == 0, "R7 no operand lost", expBladeQ.size(), 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    testReset();
    testSingle();
    testSignature();
    testHazard();
    testNoHazard();
    testInvalid();
    testStream();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule